// File: doc/BRIEF.md
# T1 Loopback Code Detector

This block watches a received T1 serial bit stream, one bit per strobe, for the two repeating in-band loop codes. The loop-up code repeats 00001 and the loop-down code repeats 001. Each code can arrive framed, with framing bits interleaved that carry unrelated values, or unframed, where the pattern fills every bit. A status flag for a code rises once that code has lasted the persistence time. The default of 74112 bits is 48 ms at 1.544 Mb/s. Scattered bit errors at a rate of about 3e-3 do not break detection.

For each code, two checking lanes run side by side. The framed lane skips bits that carry the framing marker. The unframed lane takes every valid bit. Either lane can satisfy detection. A lane learns the code's phase on its own: it compares each bit with the bit one code period earlier and scores those mismatches over fixed blocks of bits. Runs of good blocks add up to the persistence time. A flag drops at the end of the first block in which its code is missing. A small arbiter keeps the two flags apart.

Top module: `loopback_code_detector`

## Requirements
- R1: After a synchronous active-low reset, both `loop_up_det` and `loop_down_det` are 0.
- R2: An unframed 00001 stream raises `loop_up_det` once the number of good blocks reaches ceil(PERSIST_BITS/BLOCK_BITS). The flag rises two clocks after the bit that closes the last of these blocks. `loop_down_det` stays 0.
- R3: An unframed 001 stream that persists the same number of good blocks raises `loop_down_det`, and `loop_up_det` stays 0.
- R4: In the framed lanes, a bit strobed while `rx_frm_bit` is 1 is not taken, whatever its value. A code carried with interleaved framing bits is therefore still detected.
- R5: No flag rises before the required number of good blocks has completed. With one good block fewer, the flag is still 0.
- R6: A mismatch is a taken bit that differs from the bit taken one code period (5 or 3 taken bits) earlier. Mismatches are not counted for the first period of taken bits after reset. A block of BLOCK_BITS taken bits, counted from reset, is good when it holds at most MAX_ERR mismatches. A mismatch on the bit that closes a block counts toward that block.
- R7: A block with more than MAX_ERR mismatches sets that lane's run of good blocks back to zero. A flag whose code no longer holds in any lane falls at the end of that block.
- R8: A block is good only if its count of ones, times 2 times the code period, lies between BLOCK_BITS and 3 times BLOCK_BITS. An all-zero or all-one line never raises a flag.
- R9: While `rx_bit_vld` is 0, `rx_bit` and `rx_frm_bit` have no effect on any lane.
- R10: The two flags are never 1 together. A new detection of one code clears the other flag. If both codes become detected in the same cycle, the loop-down flag wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_bit | input | 1 | Received line data bit |
| rx_bit_vld | input | 1 | Strobe: `rx_bit` holds a new bit this cycle |
| rx_frm_bit | input | 1 | Marks the strobed bit as a framing bit |
| loop_up_det | output | 1 | Loop-up (00001) code detected |
| loop_down_det | output | 1 | Loop-down (001) code detected |

## Verification
Two things can land on the same cycle: the arrival of a mismatch and the closing of an error-check block. The bench aims bit flips at exact offsets inside a block, which it can do because blocks are aligned to reset. One flip well inside a block costs exactly the limit of two mismatches, so the block must pass and the flag must stay. A second flip on the block's final bit adds a third mismatch in that same closing cycle, so the block must fail and the flag must fall at that boundary. The bench also switches from one code straight to the other. This checks that the old flag falls at the first failing block and that the newer code's flag takes over.

// File: rtl/lcd_pkg.sv
// Package: shared constants and helpers for the loopback code detector.
// Assumes: code periods are fixed by the line standard; everything else is a parameter.
package lcd_pkg;
    localparam int UP_PERIOD   = 5;   // 00001 repeating
    localparam int DOWN_PERIOD = 3;   // 001 repeating

    // Integer ceiling division used to turn a bit count into a block count.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/lcd_code_lane.sv
// Module: one checking lane for one code period, framed or unframed.
// It compares each taken bit with the bit one period earlier and counts mismatches
// and ones over fixed blocks. It keeps a saturating run of good blocks and reports a
// hit while that run has reached NEED_BLOCKS.
// Assumes: blocks are aligned to reset; the framed lane skips marker bits.
module lcd_code_lane #(
    parameter int PERIOD      = 5,
    parameter bit FRAMED      = 1'b0,
    parameter int BLOCK_BITS  = 1000,
    parameter int MAX_ERR     = 8,
    parameter int NEED_BLOCKS = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic vld_i,
    input  logic frm_i,
    output logic hit_o
);
    localparam int PW = $clog2(PERIOD + 1);
    localparam int CW = $clog2(BLOCK_BITS);
    localparam int EW = $clog2(BLOCK_BITS + 1);
    localparam int GW = $clog2(NEED_BLOCKS + 1);

    logic [PERIOD-1:0] hist;
    logic [PW-1:0]     prime_cnt;
    logic [CW-1:0]     blk_cnt;
    logic [EW-1:0]     err_cnt, ones_cnt, err_next, ones_next;
    logic [GW-1:0]     good_cnt;
    logic              acc, primed, mismatch, blk_last, blk_good;
    logic [31:0]       dens;

    // Decide whether this strobe is a bit this lane takes.
    always_comb acc = vld_i && !(FRAMED && frm_i);

    // Score the incoming bit and judge the block when it closes.
    always_comb begin
        primed    = (prime_cnt == PW'(PERIOD));
        mismatch  = primed && (bit_i != hist[PERIOD-1]);
        err_next  = err_cnt + EW'(mismatch);
        ones_next = ones_cnt + EW'(bit_i);
        blk_last  = (blk_cnt == CW'(BLOCK_BITS - 1));
        dens      = 32'(ones_next) * 32'(2 * PERIOD);
        blk_good  = (32'(err_next) <= 32'(MAX_ERR)) &&
                    (dens >= 32'(BLOCK_BITS)) && (dens <= 32'(3 * BLOCK_BITS));
    end

    // Advance history, block counters and the good-block run on each taken bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist      <= '0;
            prime_cnt <= '0;
            blk_cnt   <= '0;
            err_cnt   <= '0;
            ones_cnt  <= '0;
            good_cnt  <= '0;
        end else if (acc) begin
            hist <= {hist[PERIOD-2:0], bit_i};
            if (!primed) prime_cnt <= prime_cnt + 1'b1;
            if (blk_last) begin
                blk_cnt  <= '0;
                err_cnt  <= '0;
                ones_cnt <= '0;
                if (!blk_good)
                    good_cnt <= '0;
                else if (good_cnt != GW'(NEED_BLOCKS))
                    good_cnt <= good_cnt + 1'b1;
            end else begin
                blk_cnt  <= blk_cnt + 1'b1;
                err_cnt  <= err_next;
                ones_cnt <= ones_next;
            end
        end
    end

    // Report the hit while the run of good blocks is complete.
    always_comb hit_o = (good_cnt == GW'(NEED_BLOCKS));

    AST_BAD_BLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && blk_last && !blk_good) |=> (good_cnt == '0)); // R7
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc) |=> $stable(good_cnt)); // R9
    AST_HIT_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_o) |-> $past(acc)); // R5
endmodule

// File: rtl/lcd_flag_arbiter.sv
// Module: turns the per-code hits into two exclusive status flags.
// A newly rising hit claims its flag and clears the other one. If both rise at once,
// the loop-down flag wins. A flag falls as soon as its hit is gone.
// Assumes: hits come straight from lane registers.
module lcd_flag_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic up_hit,
    input  logic down_hit,
    output logic up_flag,
    output logic down_flag
);
    logic up_hit_q, down_hit_q, up_rise, down_rise;

    // Find fresh detections.
    always_comb begin
        up_rise   = up_hit && !up_hit_q;
        down_rise = down_hit && !down_hit_q;
    end

    // Remember last cycle's hits for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_hit_q   <= 1'b0;
            down_hit_q <= 1'b0;
        end else begin
            up_hit_q   <= up_hit;
            down_hit_q <= down_hit;
        end
    end

    // Update flags: newest detection wins, lost codes drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_flag   <= 1'b0;
            down_flag <= 1'b0;
        end else if (down_rise) begin
            down_flag <= 1'b1;
            up_flag   <= 1'b0;
        end else if (up_rise) begin
            up_flag   <= 1'b1;
            down_flag <= 1'b0;
        end else begin
            if (!up_hit)   up_flag   <= 1'b0;
            if (!down_hit) down_flag <= 1'b0;
        end
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_flag && down_flag)); // R10
    AST_NEWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        down_rise |=> (down_flag && !up_flag)); // R10
    AST_FLAG_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
        up_flag |-> up_hit_q); // R7
endmodule

// File: rtl/loopback_code_detector.sv
// Module: top of the loopback code detector.
// It builds four lanes (two codes, each framed and unframed), merges the lanes per code
// and arbitrates the two status flags.
// Assumes: one bit per rx_bit_vld strobe; persistence is rounded up to whole blocks.
module loopback_code_detector #(
    parameter int PERSIST_BITS = 74112,
    parameter int BLOCK_BITS   = 1000,
    parameter int MAX_ERR      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic rx_bit_vld,
    input  logic rx_frm_bit,
    output logic loop_up_det,
    output logic loop_down_det
);
    import lcd_pkg::*;

    localparam int NEED_BLOCKS = ceil_div(PERSIST_BITS, BLOCK_BITS);
    localparam int NUM_LANES   = 4;

    logic [NUM_LANES-1:0] lane_hit;
    logic                 up_hit, down_hit;

    // Lanes 0,1 check the loop-up code; lanes 2,3 the loop-down code; odd lanes are framed.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LANE_PERIOD = (g < 2) ? UP_PERIOD : DOWN_PERIOD;
        localparam bit LANE_FRAMED = (g % 2) == 1;
        lcd_code_lane #(
            .PERIOD     (LANE_PERIOD),
            .FRAMED     (LANE_FRAMED),
            .BLOCK_BITS (BLOCK_BITS),
            .MAX_ERR    (MAX_ERR),
            .NEED_BLOCKS(NEED_BLOCKS)
        ) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .bit_i(rx_bit),
            .vld_i(rx_bit_vld),
            .frm_i(rx_frm_bit),
            .hit_o(lane_hit[g])
        );
    end

    // Either lane of a code may satisfy detection.
    always_comb begin
        up_hit   = |lane_hit[1:0];
        down_hit = |lane_hit[3:2];
    end

    lcd_flag_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_hit   (up_hit),
        .down_hit (down_hit),
        .up_flag  (loop_up_det),
        .down_flag(loop_down_det)
    );
endmodule

// File: tb/sim_loopback_code_detector.sv
// Directed bench: small blocks (40 bits, limit 2 mismatches, 3 blocks of persistence).
module sim_loopback_code_detector;
    localparam int CLK_PERIOD = 10;
    localparam int BLK  = 40;
    localparam int MAXE = 2;
    localparam int PERS = 120;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0, rx_bit_vld = 1'b0, rx_frm_bit = 1'b0;
    logic loop_up_det, loop_down_det;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    int cyc = 0;
    logic frm_val = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    loopback_code_detector #(.PERSIST_BITS(PERS), .BLOCK_BITS(BLK), .MAX_ERR(MAXE)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .rx_frm_bit(rx_frm_bit), .loop_up_det(loop_up_det), .loop_down_det(loop_down_det)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG_CYCLES) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG_CYCLES);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_bit_vld = 1'b0; rx_frm_bit = 1'b0; rx_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ph = 0;
    endtask

    task automatic put_bit(input logic b, input logic f);
        @(negedge clk);
        rx_bit = b; rx_frm_bit = f; rx_bit_vld = 1'b1;
    endtask

    task automatic settle();
        @(negedge clk);
        rx_bit_vld = 1'b0; rx_frm_bit = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Send nbits of the code with period p; flip offsets fa/fb; framing bit after every fe bits.
    task automatic send_code(input int p, input int nbits, input int fa, input int fb, input int fe);
        for (int k = 0; k < nbits; k++) begin
            logic b;
            b = ((ph % p) == p - 1);
            if (k == fa || k == fb) b = ~b;
            put_bit(b, 1'b0);
            ph++;
            if (fe > 0 && (k % fe) == fe - 1) begin
                put_bit(frm_val, 1'b1);
                frm_val = ~frm_val;
            end
        end
    endtask

    task automatic send_const(input logic v, input int nbits);
        for (int k = 0; k < nbits; k++) put_bit(v, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 up flag after reset", loop_up_det, 1'b0);
        check("R1 down flag after reset", loop_down_det, 1'b0);
    endtask

    task automatic t_loop_up();
        do_reset();
        send_code(5, 2 * BLK, -1, -1, 0);
        settle();
        check("R5 up flag one block early", loop_up_det, 1'b0);
        send_code(5, BLK, -1, -1, 0);
        settle();
        check("R2 up flag after persistence", loop_up_det, 1'b1);
        check("R2 down flag stays low", loop_down_det, 1'b0);
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            rx_bit_vld = 1'b0; rx_bit = k[0]; rx_frm_bit = k[1];
        end
        settle();
        check("R9 up flag after ignored strobeless bits", loop_up_det, 1'b1);
        send_code(5, BLK, -1, -1, 0);
        settle();
        check("R9 block alignment kept", loop_up_det, 1'b1);
    endtask

    task automatic t_down_then_up();
        do_reset();
        send_code(3, 3 * BLK, -1, -1, 0);
        settle();
        check("R3 down flag after persistence", loop_down_det, 1'b1);
        check("R3 up flag stays low", loop_up_det, 1'b0);
        ph = 0;
        send_code(5, BLK, -1, -1, 0);
        settle();
        check("R7 down flag falls after failing block", loop_down_det, 1'b0);
        check("R7 up flag not yet", loop_up_det, 1'b0);
        send_code(5, 3 * BLK, -1, -1, 0);
        settle();
        check("R10 newer up detection", loop_up_det, 1'b1);
        check("R10 down flag clear", loop_down_det, 1'b0);
    endtask

    task automatic t_errors();
        do_reset();
        send_code(5, 3 * BLK, -1, -1, 0);
        settle();
        check("R2 up flag before error blocks", loop_up_det, 1'b1);
        send_code(5, BLK, 10, -1, 0);      // mismatches at 10 and 15: at the limit
        settle();
        check("R6 block at mismatch limit stays good", loop_up_det, 1'b1);
        send_code(5, BLK, 10, BLK - 1, 0); // third mismatch on the closing bit
        settle();
        check("R7 closing-bit mismatch fails block", loop_up_det, 1'b0);
    endtask

    task automatic t_framed();
        do_reset();
        send_code(5, 3 * BLK, -1, -1, 7);
        settle();
        check("R4 framed up code detected", loop_up_det, 1'b1);
        check("R4 framed down flag low", loop_down_det, 1'b0);
        do_reset();
        send_code(3, 3 * BLK, -1, -1, 6);
        settle();
        check("R4 framed down code detected", loop_down_det, 1'b1);
    endtask

    task automatic t_density();
        do_reset();
        send_const(1'b0, 5 * BLK);
        settle();
        check("R8 all zeros up flag", loop_up_det, 1'b0);
        check("R8 all zeros down flag", loop_down_det, 1'b0);
        do_reset();
        send_const(1'b1, 5 * BLK);
        settle();
        check("R8 all ones up flag", loop_up_det, 1'b0);
        check("R8 all ones down flag", loop_down_det, 1'b0);
    endtask

    initial begin
        t_reset();
        t_loop_up();
        t_down_then_up();
        t_errors();
        t_framed();
        t_density();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule